// File: doc/BRIEF.md
# BCD Calendar Clock Register Window

This block keeps a wall-clock calendar of seconds, minutes, hours, weekday, date, month and two-digit year. Every field is held in packed BCD. A one-second tick advances the calendar. A small state machine applies the carry one field per cycle: seconds first, then minutes, hours, the day fields, month and year. A register file of eight bytes gives a host access to the calendar. Each write loads one field, but only after the value has passed a range and BCD-digit check.

The seconds register also holds a stop flag that freezes the calendar. The weekday register also holds a century flag that the host sets and the calendar never changes. A control byte stores what the host writes, except that some bits are forced to fixed values. While a carry is rippling, every read returns a snapshot taken at the tick, so the host never sees a half-updated time. The parameter `YEAR_BASE` gives the calendar year that year register 00 stands for, and the leap-year phase is derived from it.

Top module: `rtc_bcd_regs`

State machine: `ST_IDLE` waits for a tick. `ST_SEC`, `ST_MIN`, `ST_HOUR`, `ST_DAY`, `ST_MONTH` and `ST_YEAR` each advance one field. `ST_COMMIT` settles the result and reloads the snapshot. The transitions are as follows:
- IDLE goes to SEC on a tick while the stop flag is clear.
- Each field state goes to the next field state when its field wraps. Otherwise it goes to COMMIT.
- YEAR always goes to COMMIT.
- COMMIT always goes to IDLE.

## Requirements
- R1: After reset the registers read as follows: control 0x90, seconds 0x00 with the stop flag clear, minutes 0x00, hours 0x00, weekday 0x01 with the century flag clear, date 0x01, month 0x01 and year 0x00.
- R2: Register index on `addr`: 0 control, 1 seconds, 2 minutes, 3 hours, 4 weekday/century, 5 date, 6 month, 7 year. A read strobe at a clock edge places the byte on `rdata` after that same edge, and `rdata` holds until the next strobe.
- R3: A seconds write always stores `wdata[7]` as the stop flag. It loads `wdata[6:0]` as seconds only when that value is valid BCD in 00..59. A read returns the stop flag in bit 7 and the seconds in bits 6:0.
- R4: A minutes write loads `wdata[6:0]` when it is valid BCD in 00..59. An hours write loads `wdata[5:0]` when it is valid BCD in 00..23. Any other write to these two registers is ignored. Bits above each field are dropped and read back as zero.
- R5: A weekday write loads `wdata[2:0]` as the weekday and stores `wdata[6]` as the century flag. All other bits are dropped. A read returns the century flag in bit 6 and the weekday in bits 2:0, with every other bit zero.
- R6: A date write loads `wdata[5:0]` when it is BCD 01..31. A month write loads `wdata[4:0]` when it is BCD 01..12. A year write loads all 8 bits when they are BCD 00..99. Any other write to these registers is ignored.
- R7: A control write stores `(wdata & 0x5F) | 0x90`, so bits 7 and 4 read back as one and bit 5 reads back as zero.
- R8: A tick with the stop flag clear adds one second. The carry chain works as follows:
  - Seconds 59 becomes 00 and carries into minutes.
  - Minutes 59 becomes 00 and carries into hours.
  - Hours 23 becomes 00 and advances both the date and the weekday.
  - The weekday goes from 7 (or 0) to 1.
- R9: A date at or beyond the last day of its month wraps to 01 and carries into the month. April, June, September and November end at 30, and the other months end at 31. February ends at 29 when (year + YEAR_BASE) is divisible by 4, and at 28 otherwise. Month 12 carries into the year, and year 99 wraps to 00. The century flag is left unchanged.
- R10: While the stop flag is set, ticks have no effect. After the flag is cleared, counting resumes from the stored value.
- R11: From the tick edge until the carry has finished, reads return the calendar as it stood before the tick. The carry finishes within 7 cycles. A tick that arrives while a carry is in progress is ignored.
- R12: A tick in the same cycle as a valid seconds write advances the newly written value by one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One-second advance strobe |
| wr_en | input | 1 | Write strobe for the selected register |
| rd_en | input | 1 | Read strobe for the selected register |
| addr | input | 3 | Register index |
| wdata | input | 8 | Write byte |
| rdata | output | 8 | Read byte, registered |

## Verification
Two events can fall in the same cycle: a host write and the tick that starts a carry. Two related collisions are also tested: a read issued while the carry is still rippling, and a second tick that arrives before the carry has finished. The bench raises the tick together with a seconds write and expects to read back the written value plus one. It issues minute reads on each of the three busy cycles of an hour carry and expects the pre-tick value each time. It holds the tick high across a whole carry and expects the calendar to have advanced exactly once.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

    localparam int REG_AW = 3;
    localparam int BYTE_W = 8;

    typedef enum logic [2:0] {
        ST_IDLE, ST_SEC, ST_MIN, ST_HOUR, ST_DAY, ST_MONTH, ST_YEAR, ST_COMMIT
    } rtc_state_e;

    typedef enum logic [REG_AW-1:0] {
        RI_CTRL  = 3'd0,
        RI_SEC   = 3'd1,
        RI_MIN   = 3'd2,
        RI_HOUR  = 3'd3,
        RI_WDAY  = 3'd4,
        RI_DATE  = 3'd5,
        RI_MONTH = 3'd6,
        RI_YEAR  = 3'd7
    } rtc_reg_e;

    typedef struct packed {
        logic       stop;
        logic [6:0] sec;
        logic [6:0] min;
        logic [5:0] hour;
        logic       century;
        logic [2:0] wday;
        logic [5:0] date;
        logic [4:0] month;
        logic [7:0] year;
        logic [7:0] ctrl;
    } rtc_time_t;

    typedef struct packed {
        logic sec;
        logic min;
        logic hour;
        logic day;
        logic month;
        logic year;
    } rtc_step_t;

    localparam rtc_time_t RESET_TIME = '{
        stop: 1'b0, sec: 7'h00, min: 7'h00, hour: 6'h00, century: 1'b0,
        wday: 3'd1, date: 6'h01, month: 5'h01, year: 8'h00, ctrl: 8'h90
    };

    localparam logic [7:0] CTRL_KEEP  = 8'h5F;
    localparam logic [7:0] CTRL_FORCE = 8'h90;

    function automatic logic bcd_in_range(logic [7:0] v, logic [7:0] lo, logic [7:0] hi);
        return (v[3:0] <= 4'd9) && (v[7:4] <= 4'd9) && (v >= lo) && (v <= hi);
    endfunction

    function automatic logic [7:0] bcd_next(logic [7:0] v);
        if (v[3:0] >= 4'd9)
            return {v[7:4] + 4'd1, 4'd0};
        else
            return v + 8'd1;
    endfunction

    function automatic logic [7:0] bcd_to_bin(logic [7:0] v);
        return ({4'd0, v[7:4]} * 8'd10) + {4'd0, v[3:0]};
    endfunction

    function automatic logic leap_year(logic [7:0] yr, logic [1:0] phase);
        logic [7:0] b;
        b = bcd_to_bin(yr) + {6'd0, phase};
        return (b[1:0] == 2'd0);
    endfunction

    function automatic logic [7:0] month_last_day(logic [4:0] mon, logic leap);
        logic [7:0] d;
        case (mon)
            5'h02:                      d = leap ? 8'h29 : 8'h28;
            5'h04, 5'h06, 5'h09, 5'h11: d = 8'h30;
            default:                    d = 8'h31;
        endcase
        return d;
    endfunction

endpackage

// File: rtl/rtc_seq_fsm.sv
module rtc_seq_fsm
    import rtc_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      tick,
    input  logic      stop,
    input  logic      sec_wrap,
    input  logic      min_wrap,
    input  logic      hour_wrap,
    input  logic      date_wrap,
    input  logic      month_wrap,
    output rtc_step_t step,
    output logic      busy,
    output logic      refresh
);

    rtc_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (tick && !stop) state_d = ST_SEC;
            ST_SEC:    state_d = sec_wrap   ? ST_MIN   : ST_COMMIT;
            ST_MIN:    state_d = min_wrap   ? ST_HOUR  : ST_COMMIT;
            ST_HOUR:   state_d = hour_wrap  ? ST_DAY   : ST_COMMIT;
            ST_DAY:    state_d = date_wrap  ? ST_MONTH : ST_COMMIT;
            ST_MONTH:  state_d = month_wrap ? ST_YEAR  : ST_COMMIT;
            ST_YEAR:   state_d = ST_COMMIT;
            ST_COMMIT: state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        step    = '0;
        busy    = 1'b1;
        refresh = 1'b0;
        unique case (state_q)
            ST_IDLE:   begin busy = 1'b0; refresh = 1'b1; end
            ST_SEC:    step.sec   = 1'b1;
            ST_MIN:    step.min   = 1'b1;
            ST_HOUR:   step.hour  = 1'b1;
            ST_DAY:    step.day   = 1'b1;
            ST_MONTH:  step.month = 1'b1;
            ST_YEAR:   step.year  = 1'b1;
            ST_COMMIT: refresh    = 1'b1;
        endcase
    end

endmodule

// File: rtl/rtc_time_regs.sv
module rtc_time_regs
    import rtc_pkg::*;
#(
    parameter int YEAR_BASE = 1968
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [REG_AW-1:0] addr,
    input  logic [BYTE_W-1:0] wdata,
    input  rtc_step_t         step,
    output rtc_time_t         live,
    output logic              sec_wrap,
    output logic              min_wrap,
    output logic              hour_wrap,
    output logic              date_wrap,
    output logic              month_wrap
);

    localparam logic [1:0] LEAP_PHASE = 2'(YEAR_BASE % 4);

    logic [7:0] sec_nx, min_nx, hour_nx, date_nx, month_nx, year_nx, last_day;
    logic [2:0] wday_nx;
    logic       wr_ctrl, wr_sec, wr_min, wr_hour, wr_wday, wr_date, wr_month, wr_year;
    logic       ok_sec, ok_min, ok_hour, ok_date, ok_month, ok_year;

    always_comb begin
        last_day   = month_last_day(live.month, leap_year(live.year, LEAP_PHASE));
        sec_wrap   = ({1'b0, live.sec}  == 8'h59);
        min_wrap   = ({1'b0, live.min}  == 8'h59);
        hour_wrap  = ({2'b0, live.hour} == 8'h23);
        date_wrap  = ({2'b0, live.date} >= last_day);
        month_wrap = ({3'b0, live.month} >= 8'h12);
        sec_nx     = sec_wrap   ? 8'h00 : bcd_next({1'b0, live.sec});
        min_nx     = min_wrap   ? 8'h00 : bcd_next({1'b0, live.min});
        hour_nx    = hour_wrap  ? 8'h00 : bcd_next({2'b0, live.hour});
        date_nx    = date_wrap  ? 8'h01 : bcd_next({2'b0, live.date});
        month_nx   = month_wrap ? 8'h01 : bcd_next({3'b0, live.month});
        year_nx    = (live.year == 8'h99) ? 8'h00 : bcd_next(live.year);
        wday_nx    = (live.wday >= 3'd7 || live.wday == 3'd0) ? 3'd1 : live.wday + 3'd1;
    end

    always_comb begin
        wr_ctrl  = wr_en && (addr == RI_CTRL);
        wr_sec   = wr_en && (addr == RI_SEC);
        wr_min   = wr_en && (addr == RI_MIN);
        wr_hour  = wr_en && (addr == RI_HOUR);
        wr_wday  = wr_en && (addr == RI_WDAY);
        wr_date  = wr_en && (addr == RI_DATE);
        wr_month = wr_en && (addr == RI_MONTH);
        wr_year  = wr_en && (addr == RI_YEAR);
        ok_sec   = bcd_in_range({1'b0, wdata[6:0]}, 8'h00, 8'h59);
        ok_min   = bcd_in_range({1'b0, wdata[6:0]}, 8'h00, 8'h59);
        ok_hour  = bcd_in_range({2'b0, wdata[5:0]}, 8'h00, 8'h23);
        ok_date  = bcd_in_range({2'b0, wdata[5:0]}, 8'h01, 8'h31);
        ok_month = bcd_in_range({3'b0, wdata[4:0]}, 8'h01, 8'h12);
        ok_year  = bcd_in_range(wdata, 8'h00, 8'h99);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            live <= RESET_TIME;
        end else begin
            if (wr_ctrl)
                live.ctrl <= (wdata & CTRL_KEEP) | CTRL_FORCE;

            if (wr_sec)
                live.stop <= wdata[7];
            if (wr_sec && ok_sec)
                live.sec <= wdata[6:0];
            else if (step.sec)
                live.sec <= sec_nx[6:0];

            if (wr_min && ok_min)
                live.min <= wdata[6:0];
            else if (step.min)
                live.min <= min_nx[6:0];

            if (wr_hour && ok_hour)
                live.hour <= wdata[5:0];
            else if (step.hour)
                live.hour <= hour_nx[5:0];

            if (wr_wday) begin
                live.century <= wdata[6];
                live.wday    <= wdata[2:0];
            end else if (step.day) begin
                live.wday    <= wday_nx;
            end

            if (wr_date && ok_date)
                live.date <= wdata[5:0];
            else if (step.day)
                live.date <= date_nx[5:0];

            if (wr_month && ok_month)
                live.month <= wdata[4:0];
            else if (step.month)
                live.month <= month_nx[4:0];

            if (wr_year && ok_year)
                live.year <= wdata;
            else if (step.year)
                live.year <= year_nx;
        end
    end

endmodule

// File: rtl/rtc_read_view.sv
module rtc_read_view
    import rtc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  rtc_time_t         live,
    input  logic              busy,
    input  logic              refresh,
    input  logic              rd_en,
    input  logic [REG_AW-1:0] addr,
    output logic [BYTE_W-1:0] rdata,
    output rtc_time_t         snap
);

    rtc_time_t  view;
    logic [7:0] byte_sel;

    always_ff @(posedge clk) begin
        if (!rst_n)
            snap <= RESET_TIME;
        else if (refresh)
            snap <= live;
    end

    always_comb begin
        view = busy ? snap : live;
        unique case (addr)
            RI_CTRL:  byte_sel = view.ctrl;
            RI_SEC:   byte_sel = {view.stop, view.sec};
            RI_MIN:   byte_sel = {1'b0, view.min};
            RI_HOUR:  byte_sel = {2'b0, view.hour};
            RI_WDAY:  byte_sel = {1'b0, view.century, 3'b000, view.wday};
            RI_DATE:  byte_sel = {2'b0, view.date};
            RI_MONTH: byte_sel = {3'b0, view.month};
            RI_YEAR:  byte_sel = view.year;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            rdata <= '0;
        else if (rd_en)
            rdata <= byte_sel;
    end

endmodule

// File: rtl/rtc_bcd_regs.sv
module rtc_bcd_regs
    import rtc_pkg::*;
#(
    parameter int YEAR_BASE = 1968
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [REG_AW-1:0] addr,
    input  logic [BYTE_W-1:0] wdata,
    output logic [BYTE_W-1:0] rdata
);

    rtc_time_t live_q, snap_q;
    rtc_step_t step;
    logic      busy, refresh;
    logic      sec_wrap, min_wrap, hour_wrap, date_wrap, month_wrap;

    rtc_seq_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .tick(tick), .stop(live_q.stop),
        .sec_wrap(sec_wrap), .min_wrap(min_wrap), .hour_wrap(hour_wrap),
        .date_wrap(date_wrap), .month_wrap(month_wrap),
        .step(step), .busy(busy), .refresh(refresh)
    );

    rtc_time_regs #(.YEAR_BASE(YEAR_BASE)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .step(step), .live(live_q),
        .sec_wrap(sec_wrap), .min_wrap(min_wrap), .hour_wrap(hour_wrap),
        .date_wrap(date_wrap), .month_wrap(month_wrap)
    );

    rtc_read_view u_view (
        .clk(clk), .rst_n(rst_n), .live(live_q), .busy(busy), .refresh(refresh),
        .rd_en(rd_en), .addr(addr), .rdata(rdata), .snap(snap_q)
    );

endmodule

// File: rtl/rtc_bcd_regs_chk.sv
module rtc_bcd_regs_chk
    import rtc_pkg::*;
#(
    parameter int MAX_BUSY = 7
) (
    input logic              clk,
    input logic              rst_n,
    input logic              tick,
    input logic              rd_en,
    input logic [REG_AW-1:0] addr,
    input logic [BYTE_W-1:0] rdata,
    input logic              busy,
    input logic              stop,
    input rtc_time_t         snap
);

    localparam int CW = $clog2(MAX_BUSY + 1);
    localparam logic [CW-1:0] RUN_MAX = CW'(MAX_BUSY);
    logic [CW-1:0] busy_run;

    always_ff @(posedge clk) begin
        if (!rst_n)
            busy_run <= '0;
        else if (!busy)
            busy_run <= '0;
        else if (busy_run != RUN_MAX)
            busy_run <= busy_run + 1'b1;
    end

    // R7
    ctrl_forced_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr == RI_CTRL) |=> ((rdata & 8'hB0) == 8'h90));

    // R4
    hour_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr == RI_HOUR) |=> (rdata[7:6] == 2'b00));

    // R5
    wday_dropped_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr == RI_WDAY) |=> ((rdata & 8'hB8) == 8'h00));

    // R6
    month_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr == RI_MONTH) |=> (rdata != 8'h00 && rdata <= 8'h12));

    // R8
    tick_starts_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && tick && !stop) |=> busy);

    // R10
    stop_blocks_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && tick && stop) |=> !busy);

    // R11
    snapshot_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(snap));

    // R11
    carry_bounded_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (busy_run < RUN_MAX));

endmodule

bind rtc_bcd_regs rtc_bcd_regs_chk #(.MAX_BUSY(7)) u_chk (
    .clk(clk), .rst_n(rst_n), .tick(tick), .rd_en(rd_en), .addr(addr),
    .rdata(rdata), .busy(busy), .stop(live_q.stop), .snap(snap_q)
);

// File: tb/sim_rtc_bcd_regs.sv
module sim_rtc_bcd_regs;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic       wr_en = 1'b0;
    logic       rd_en = 1'b0;
    logic [2:0] addr = 3'd0;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    rtc_bcd_regs u0 (
        .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .rd_en(rd_en),
        .addr(addr), .wdata(wdata), .rdata(rdata)
    );

    // {requirement, index, write byte, expected read-back}
    localparam logic [22:0] VEC [26] = '{
        {4'd3, 3'd1, 8'h45, 8'h45}, {4'd3, 3'd1, 8'h60, 8'h45}, {4'd3, 3'd1, 8'h3A, 8'h45},
        {4'd3, 3'd1, 8'hDA, 8'hC5}, {4'd3, 3'd1, 8'h12, 8'h12},
        {4'd4, 3'd2, 8'h59, 8'h59}, {4'd4, 3'd2, 8'hE0, 8'h59}, {4'd4, 3'd2, 8'h87, 8'h07},
        {4'd4, 3'd3, 8'h23, 8'h23}, {4'd4, 3'd3, 8'h24, 8'h23}, {4'd4, 3'd3, 8'hD5, 8'h15},
        {4'd4, 3'd3, 8'h1A, 8'h15},
        {4'd5, 3'd4, 8'hFD, 8'h45}, {4'd5, 3'd4, 8'h03, 8'h03},
        {4'd6, 3'd5, 8'h31, 8'h31}, {4'd6, 3'd5, 8'h32, 8'h31}, {4'd6, 3'd5, 8'h00, 8'h31},
        {4'd6, 3'd6, 8'h12, 8'h12}, {4'd6, 3'd6, 8'h13, 8'h12}, {4'd6, 3'd6, 8'hE9, 8'h09},
        {4'd6, 3'd7, 8'h99, 8'h99}, {4'd6, 3'd7, 8'hA0, 8'h99}, {4'd6, 3'd7, 8'h4F, 8'h99},
        {4'd7, 3'd0, 8'hFF, 8'hDF}, {4'd7, 3'd0, 8'h00, 8'h90}, {4'd7, 3'd0, 8'h2C, 8'h9C}
    };

    task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s got=%02h exp=%02h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd_chk(input string tag, input logic [2:0] a, input logic [7:0] exp);
        @(negedge clk);
        rd_en = 1'b1; addr = a;
        @(negedge clk);
        rd_en = 1'b0;
        check(tag, rdata, exp);
    endtask

    task automatic pulse_tick();
        @(negedge clk); tick = 1'b1;
        @(negedge clk); tick = 1'b0;
        repeat (10) @(negedge clk);
    endtask

    task automatic set_clock(input logic [7:0] yr, input logic [7:0] mo, input logic [7:0] dt,
                             input logic [7:0] hr, input logic [7:0] mi, input logic [7:0] se);
        wr(3'd7, yr); wr(3'd6, mo); wr(3'd5, dt);
        wr(3'd3, hr); wr(3'd2, mi); wr(3'd1, se);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog expired");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset contents, R2 index map and one-cycle read latency
        rd_chk("R1 R2 ctrl",  3'd0, 8'h90);
        rd_chk("R1 R2 sec",   3'd1, 8'h00);
        rd_chk("R1 R2 min",   3'd2, 8'h00);
        rd_chk("R1 R2 hour",  3'd3, 8'h00);
        rd_chk("R1 R2 wday",  3'd4, 8'h01);
        rd_chk("R1 R2 date",  3'd5, 8'h01);
        rd_chk("R1 R2 month", 3'd6, 8'h01);
        rd_chk("R1 R2 year",  3'd7, 8'h00);

        // R3 R4 R5 R6 R7 write filtering, walked from the table
        for (int i = 0; i < 26; i++) begin
            wr(VEC[i][18:16], VEC[i][15:8]);
            rd_chk($sformatf("R%0d vec%0d", VEC[i][22:19], i), VEC[i][18:16], VEC[i][7:0]);
        end

        // R8 R9 leap February 28 -> 29 with full carry, weekday 7 -> 1
        wr(3'd4, 8'h07);
        set_clock(8'h00, 8'h02, 8'h28, 8'h23, 8'h59, 8'h59);
        pulse_tick();
        rd_chk("R8 sec",   3'd1, 8'h00);
        rd_chk("R8 min",   3'd2, 8'h00);
        rd_chk("R8 hour",  3'd3, 8'h00);
        rd_chk("R8 wday",  3'd4, 8'h01);
        rd_chk("R9 leap date", 3'd5, 8'h29);
        rd_chk("R9 leap month", 3'd6, 8'h02);

        // R9 February 29 -> March 1
        set_clock(8'h00, 8'h02, 8'h29, 8'h23, 8'h59, 8'h59);
        pulse_tick();
        rd_chk("R9 feb29 date",  3'd5, 8'h01);
        rd_chk("R9 feb29 month", 3'd6, 8'h03);

        // R9 non-leap February 28 -> March 1
        set_clock(8'h01, 8'h02, 8'h28, 8'h23, 8'h59, 8'h59);
        pulse_tick();
        rd_chk("R9 feb28 date",  3'd5, 8'h01);
        rd_chk("R9 feb28 month", 3'd6, 8'h03);

        // R9 thirty-day month
        set_clock(8'h05, 8'h04, 8'h30, 8'h23, 8'h59, 8'h59);
        pulse_tick();
        rd_chk("R9 apr date",  3'd5, 8'h01);
        rd_chk("R9 apr month", 3'd6, 8'h05);

        // R9 year 99 -> 00, century flag kept
        wr(3'd4, 8'h47);
        set_clock(8'h99, 8'h12, 8'h31, 8'h23, 8'h59, 8'h59);
        pulse_tick();
        rd_chk("R9 year wrap",  3'd7, 8'h00);
        rd_chk("R9 month wrap", 3'd6, 8'h01);
        rd_chk("R9 date wrap",  3'd5, 8'h01);
        rd_chk("R9 century",    3'd4, 8'h41);

        // R10 stop flag freezes, clearing resumes
        wr(3'd1, 8'h85);
        pulse_tick();
        rd_chk("R10 frozen", 3'd1, 8'h85);
        wr(3'd1, 8'h05);
        pulse_tick();
        rd_chk("R10 resumed", 3'd1, 8'h06);

        // R11 reads during the carry return the pre-tick snapshot
        set_clock(8'h10, 8'h06, 8'h15, 8'h12, 8'h59, 8'h59);
        @(negedge clk); tick = 1'b1;
        @(negedge clk); tick = 1'b0; rd_en = 1'b1; addr = 3'd2;
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            check($sformatf("R11 snapshot read %0d", k), rdata, 8'h59);
        end
        rd_en = 1'b0;
        repeat (10) @(negedge clk);
        rd_chk("R11 after min",  3'd2, 8'h00);
        rd_chk("R11 after hour", 3'd3, 8'h13);

        // R11 tick held across a whole carry advances once
        set_clock(8'h10, 8'h06, 8'h15, 8'h12, 8'h10, 8'h59);
        @(negedge clk); tick = 1'b1;
        repeat (3) @(negedge clk);
        tick = 1'b0;
        repeat (10) @(negedge clk);
        rd_chk("R11 held tick sec", 3'd1, 8'h00);
        rd_chk("R11 held tick min", 3'd2, 8'h11);

        // R12 tick coincident with a seconds write
        @(negedge clk);
        wr_en = 1'b1; addr = 3'd1; wdata = 8'h30; tick = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; tick = 1'b0;
        repeat (10) @(negedge clk);
        rd_chk("R12 write+tick", 3'd1, 8'h31);

        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule